// File: doc/BRIEF.md
# Reversible Audio Crossfade Blender

This block combines two time-aligned stereo PCM streams into one output stream. One stream is derived from an analog receiver and the other comes from a digital broadcast decoder. A single request bit sets the direction of the blend. While the request is high, a 16-bit mix weight climbs toward the digital source. While it is low, the weight falls back toward the analog source. The weight moves once per input sample strobe. Because of this, losing the digital signal never mutes the output: the mix simply slides back to the analog stream.

Before mixing, each digital sample is multiplied by two gains in turn. The first is a calibration gain trimmed at manufacture. The second is a per-station gain that the host loads while the block runs. A direction reversal may arrive at any point in a transition, and the ramp turns around on the next sample.

The ramp is a four-state machine:
- `ST_ANALOG`: weight 0.
- `ST_TO_DIG`: rising.
- `ST_DIGITAL`: weight 65535.
- `ST_TO_ANA`: falling.

Each transition is taken on an input strobe:
- ANALOG→TO_DIG on a request with a nonzero rise step.
- TO_DIG→DIGITAL when the rise saturates.
- TO_DIG→TO_ANA on a dropped request.
- DIGITAL→TO_ANA on a dropped request with a nonzero fall step.
- TO_ANA→ANALOG when the fall saturates.
- TO_ANA→TO_DIG on a renewed request.
- ANALOG→DIGITAL and DIGITAL→ANALOG directly when a single step spans the whole range.

Top module: `xfade_blender`

## Requirements
- R1: After reset, the weight is 0, `full_analog` is 1, `full_digital` is 0 and `out_valid` is 0.
- R2: On each strobe with `blend_req`=1, the weight rises by `step_up` and saturates at 65535. `full_digital` is set once the weight is 65535.
- R3: On each strobe with `blend_req`=0, the weight falls by `step_dn` and saturates at 0. `full_analog` is set once the weight is 0.
- R4: A change of `blend_req` in the middle of a transition reverses the ramp direction on the next strobe, starting from the weight reached so far.
- R5: A step of 0 holds the weight. Without a strobe, the weight never changes, whatever `blend_req` does.
- R6: The digital sample is scaled by two unsigned Q2.14 gains, `gain_cal` first and then `gain_stn`. After each product, 8192 is added and the sum is shifted arithmetically right by 14. The final result is saturated to [-32768, 32767].
- R7: Each output channel equals ((65536−w)·analog + w·scaled + 32768) >>> 16, saturated to signed 16 bits. Here w is the weight held when the sample's strobe arrives, before that strobe's update.
- R8: `out_valid` pulses exactly 2 clock cycles after each `in_valid`, once per input sample and at no other time.
- R9: `full_analog` is 1 exactly when the weight is 0, and `full_digital` is 1 exactly when the weight is 65535. The two flags are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe, one cycle per stereo sample |
| ana_l | input | 16 | Analog-path left sample, signed |
| ana_r | input | 16 | Analog-path right sample, signed |
| dig_l | input | 16 | Digital-path left sample, signed |
| dig_r | input | 16 | Digital-path right sample, signed |
| blend_req | input | 1 | 1 moves the mix toward digital, 0 toward analog |
| step_up | input | 16 | Weight increment per sample while rising |
| step_dn | input | 16 | Weight decrement per sample while falling |
| gain_cal | input | 16 | Calibration gain, unsigned Q2.14 |
| gain_stn | input | 16 | Per-station gain, unsigned Q2.14 |
| out_valid | output | 1 | Output sample strobe |
| mix_l | output | 16 | Blended left sample, signed |
| mix_r | output | 16 | Blended right sample, signed |
| full_analog | output | 1 | Weight is 0 |
| full_digital | output | 1 | Weight is 65535 |

## Verification
The ramp is driven through a complete rise to saturation and a complete fall to zero. Along the way, analog and digital samples of opposite sign are used, so every intermediate weight shows up as a distinct output value.

A partial fall followed by a renewed request separates a true reversal from a restart at either end. Zero steps, and request toggles made between strobes, show whether the weight is held or drifts.

With the mix pinned to the digital side, the gain path is probed with:
- exact unity gains;
- half-LSB rounding cases of both signs;
- arbitrary gain pairs;
- products large enough to hit both saturation limits.

A final set of mid-weight samples with full-scale values of opposite polarity exercises the mix arithmetic at its extremes.

// File: rtl/xfade_pkg.sv
package xfade_pkg;

    typedef enum logic [1:0] {
        ST_ANALOG  = 2'd0,
        ST_TO_DIG  = 2'd1,
        ST_DIGITAL = 2'd2,
        ST_TO_ANA  = 2'd3
    } blend_state_e;

    localparam int NUM_CH = 2;

endpackage

// File: rtl/xfade_weight_fsm.sv
module xfade_weight_fsm
    import xfade_pkg::*;
#(
    parameter int WW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe,
    input  logic          blend,
    input  logic [WW-1:0] step_up,
    input  logic [WW-1:0] step_dn,
    output logic [WW-1:0] weight_q,
    output logic          full_analog,
    output logic          full_digital
);

    localparam logic [WW-1:0] W_MAX = {WW{1'b1}};

    blend_state_e state_q, state_d;
    logic [WW-1:0] weight_d;
    logic [WW:0]   up_sum;
    logic          up_top, dn_bot;
    logic [WW-1:0] w_up, w_dn;

    // Candidate weights for either direction, both saturating at the ends.
    assign up_sum = {1'b0, weight_q} + {1'b0, step_up};
    assign up_top = (up_sum >= {1'b0, W_MAX});
    assign dn_bot = (step_dn >= weight_q);
    assign w_up   = up_top ? W_MAX : up_sum[WW-1:0];
    assign w_dn   = dn_bot ? '0 : (weight_q - step_dn);

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_ANALOG;
            weight_q <= '0;
        end else if (strobe) begin
            state_q  <= state_d;
            weight_q <= weight_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        weight_d = blend ? w_up : w_dn;
        unique case (state_q)
            ST_ANALOG: begin
                if (blend && (step_up != '0))
                    state_d = up_top ? ST_DIGITAL : ST_TO_DIG;
            end
            ST_TO_DIG: begin
                if (blend)
                    state_d = up_top ? ST_DIGITAL : ST_TO_DIG;
                else
                    state_d = dn_bot ? ST_ANALOG : ST_TO_ANA;
            end
            ST_DIGITAL: begin
                if (!blend && (step_dn != '0))
                    state_d = dn_bot ? ST_ANALOG : ST_TO_ANA;
            end
            ST_TO_ANA: begin
                if (!blend)
                    state_d = dn_bot ? ST_ANALOG : ST_TO_ANA;
                else
                    state_d = up_top ? ST_DIGITAL : ST_TO_DIG;
            end
        endcase
    end

    // Output process
    always_comb begin
        full_analog  = 1'b0;
        full_digital = 1'b0;
        unique case (state_q)
            ST_ANALOG:  full_analog  = 1'b1;
            ST_DIGITAL: full_digital = 1'b1;
            ST_TO_DIG,
            ST_TO_ANA:  ;
        endcase
    end

endmodule

// File: rtl/xfade_gain_stage.sv
module xfade_gain_stage #(
    parameter int DW = 16,
    parameter int GW = 16,
    parameter int GF = 14
) (
    input  logic signed [DW-1:0] din,
    input  logic        [GW-1:0] g_first,
    input  logic        [GW-1:0] g_second,
    output logic signed [DW-1:0] dout
);

    localparam int PW1 = DW + GW + 1;
    localparam int PW2 = PW1 + GW + 1;
    localparam logic signed [PW1-1:0] RND1 = PW1'(1) << (GF - 1);
    localparam logic signed [PW2-1:0] RND2 = PW2'(1) << (GF - 1);
    localparam logic signed [PW2-1:0] MAXV = (PW2'(1) << (DW - 1)) - PW2'(1);
    localparam logic signed [PW2-1:0] MINV = -(PW2'(1) << (DW - 1));

    logic signed [PW1-1:0] prod1, rnd1;
    logic signed [PW2-1:0] prod2, rnd2;

    // First gain, rounded to nearest (half rounds upward).
    assign prod1 = PW1'(din) * PW1'($signed({1'b0, g_first}));
    assign rnd1  = (prod1 + RND1) >>> GF;

    // Second gain on the rounded intermediate.
    assign prod2 = PW2'(rnd1) * PW2'($signed({1'b0, g_second}));
    assign rnd2  = (prod2 + RND2) >>> GF;

    always_comb begin
        if (rnd2 > MAXV)
            dout = MAXV[DW-1:0];
        else if (rnd2 < MINV)
            dout = MINV[DW-1:0];
        else
            dout = rnd2[DW-1:0];
    end

endmodule

// File: rtl/xfade_mix_stage.sv
module xfade_mix_stage #(
    parameter int DW = 16,
    parameter int WW = 16
) (
    input  logic signed [DW-1:0] a_in,
    input  logic signed [DW-1:0] d_in,
    input  logic        [WW-1:0] w,
    output logic signed [DW-1:0] y
);

    localparam int MW = DW + WW + 4;
    localparam logic [WW:0] FULL = (WW+1)'(1) << WW;
    localparam logic signed [MW-1:0] RND  = MW'(1) << (WW - 1);
    localparam logic signed [MW-1:0] MAXV = (MW'(1) << (DW - 1)) - MW'(1);
    localparam logic signed [MW-1:0] MINV = -(MW'(1) << (DW - 1));

    logic [WW+1:0] coef_a, coef_d;
    logic signed [MW-1:0] acc, shifted;

    assign coef_a  = {1'b0, FULL - {1'b0, w}};
    assign coef_d  = {2'b00, w};
    assign acc     = MW'(a_in) * MW'($signed(coef_a))
                   + MW'(d_in) * MW'($signed(coef_d))
                   + RND;
    assign shifted = acc >>> WW;

    always_comb begin
        if (shifted > MAXV)
            y = MAXV[DW-1:0];
        else if (shifted < MINV)
            y = MINV[DW-1:0];
        else
            y = shifted[DW-1:0];
    end

endmodule

// File: rtl/xfade_blender.sv
module xfade_blender
    import xfade_pkg::*;
#(
    parameter int DW = 16,
    parameter int WW = 16,
    parameter int GW = 16,
    parameter int GF = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] ana_l,
    input  logic [DW-1:0] ana_r,
    input  logic [DW-1:0] dig_l,
    input  logic [DW-1:0] dig_r,
    input  logic          blend_req,
    input  logic [WW-1:0] step_up,
    input  logic [WW-1:0] step_dn,
    input  logic [GW-1:0] gain_cal,
    input  logic [GW-1:0] gain_stn,
    output logic          out_valid,
    output logic [DW-1:0] mix_l,
    output logic [DW-1:0] mix_r,
    output logic          full_analog,
    output logic          full_digital
);

    localparam int NCH = NUM_CH;

    logic [WW-1:0] weight;

    logic signed [DW-1:0] ana_in [NCH];
    logic signed [DW-1:0] dig_in [NCH];
    logic signed [DW-1:0] dig_scaled [NCH];
    logic signed [DW-1:0] s1_ana [NCH];
    logic signed [DW-1:0] s1_dig [NCH];
    logic signed [DW-1:0] mixed [NCH];
    logic signed [DW-1:0] out_q [NCH];
    logic [WW-1:0] s1_w;
    logic          s1_valid;

    assign ana_in[0] = ana_l;
    assign ana_in[1] = ana_r;
    assign dig_in[0] = dig_l;
    assign dig_in[1] = dig_r;

    xfade_weight_fsm #(.WW(WW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe       (in_valid),
        .blend        (blend_req),
        .step_up      (step_up),
        .step_dn      (step_dn),
        .weight_q     (weight),
        .full_analog  (full_analog),
        .full_digital (full_digital)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        xfade_gain_stage #(.DW(DW), .GW(GW), .GF(GF)) u_gain (
            .din      (dig_in[ch]),
            .g_first  (gain_cal),
            .g_second (gain_stn),
            .dout     (dig_scaled[ch])
        );

        xfade_mix_stage #(.DW(DW), .WW(WW)) u_mix (
            .a_in (s1_ana[ch]),
            .d_in (s1_dig[ch]),
            .w    (s1_w),
            .y    (mixed[ch])
        );

        // Stage 1: capture the samples and the weight held at the strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1_ana[ch] <= '0;
                s1_dig[ch] <= '0;
            end else if (in_valid) begin
                s1_ana[ch] <= ana_in[ch];
                s1_dig[ch] <= dig_scaled[ch];
            end
        end

        // Stage 2: register the mixed result.
        always_ff @(posedge clk) begin
            if (!rst_n)
                out_q[ch] <= '0;
            else if (s1_valid)
                out_q[ch] <= mixed[ch];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_w      <= '0;
            out_valid <= 1'b0;
        end else begin
            s1_valid  <= in_valid;
            out_valid <= s1_valid;
            if (in_valid)
                s1_w <= weight;
        end
    end

    assign mix_l = out_q[0];
    assign mix_r = out_q[1];

endmodule

// File: rtl/xfade_blender_chk.sv
module xfade_blender_chk #(
    parameter int WW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          blend_req,
    input logic          out_valid,
    input logic [WW-1:0] weight,
    input logic          full_analog,
    input logic          full_digital
);

    localparam logic [WW-1:0] W_MAX = {WW{1'b1}};

    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_analog && full_digital));

    a_r9_analog_flag: assert property (@(posedge clk) disable iff (!rst_n)
        full_analog == (weight == '0));

    a_r9_digital_flag: assert property (@(posedge clk) disable iff (!rst_n)
        full_digital == (weight == W_MAX));

    a_r5_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(weight));

    a_r2_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && blend_req) |=> weight >= $past(weight));

    a_r3_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !blend_req) |=> weight <= $past(weight));

endmodule

bind xfade_blender xfade_blender_chk #(.WW(WW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .blend_req    (blend_req),
    .out_valid    (out_valid),
    .weight       (weight),
    .full_analog  (full_analog),
    .full_digital (full_digital)
);

// File: tb/xfade_blender_tb.sv
module xfade_blender_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] ana_l = '0, ana_r = '0, dig_l = '0, dig_r = '0;
    logic        blend_req = 1'b0;
    logic [15:0] step_up = '0, step_dn = '0, gain_cal = '0, gain_stn = '0;
    logic        out_valid;
    logic [15:0] mix_l, mix_r;
    logic        full_analog, full_digital;

    xfade_blender u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .ana_l(ana_l), .ana_r(ana_r), .dig_l(dig_l), .dig_r(dig_r),
        .blend_req(blend_req), .step_up(step_up), .step_dn(step_dn),
        .gain_cal(gain_cal), .gain_stn(gain_stn),
        .out_valid(out_valid), .mix_l(mix_l), .mix_r(mix_r),
        .full_analog(full_analog), .full_digital(full_digital)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int     l;
        int     r;
        longint cyc;
        string  tag;
    } exp_t;

    exp_t   sb[$];
    int     n_checks = 0;
    int     n_errors = 0;
    longint cyc_cnt = 0;
    int     model_w = 0;
    int     n_sent = 0;
    int     n_seen = 0;

    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

    function automatic int clamp16(longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    // R6 model: two Q2.14 gains, each rounded by +8192 then >>> 14.
    function automatic int scale_ref(int d, int g1, int g2);
        longint t;
        t = (longint'(d) * longint'(g1) + 8192) >>> 14;
        t = (t * longint'(g2) + 8192) >>> 14;
        return clamp16(t);
    endfunction

    // R7 model
    function automatic int mix_ref(int a, int s, int w);
        longint t;
        t = (longint'(65536 - w) * longint'(a) + longint'(w) * longint'(s) + 32768) >>> 16;
        return clamp16(t);
    endfunction

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_flags(string req);
        check({req, " full_analog"},  int'(full_analog),  int'(model_w == 0));
        check({req, " full_digital"}, int'(full_digital), int'(model_w == 65535));
    endtask

    // Driver: present one stereo sample, record the expected mix, update the weight model.
    task automatic send(int al, int ar, int dl, int dr, bit b, string req);
        exp_t e;
        @(negedge clk);
        ana_l = 16'(al); ana_r = 16'(ar);
        dig_l = 16'(dl); dig_r = 16'(dr);
        blend_req = b;
        in_valid  = 1'b1;
        e.l   = mix_ref(al, scale_ref(dl, int'(gain_cal), int'(gain_stn)), model_w);
        e.r   = mix_ref(ar, scale_ref(dr, int'(gain_cal), int'(gain_stn)), model_w);
        e.cyc = cyc_cnt;
        e.tag = req;
        sb.push_back(e);
        n_sent++;
        if (b) model_w = (model_w + int'(step_up) > 65535) ? 65535 : model_w + int'(step_up);
        else   model_w = (model_w - int'(step_dn) < 0) ? 0 : model_w - int'(step_dn);
        @(negedge clk);
        in_valid = 1'b0;
        check_flags(req);
    endtask

    // Monitor: compare each output sample with the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            n_seen++;
            if (sb.size() == 0) begin
                n_checks++;
                n_errors++;
                $display("FAIL R8: unexpected out_valid actual=1 expected=0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " latency R8"}, int'(cyc_cnt - e.cyc), 2);
                check({e.tag, " left"},  int'($signed(mix_l)), e.l);
                check({e.tag, " right"}, int'($signed(mix_r)), e.r);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 full_analog", int'(full_analog), 1);
        check("R1 full_digital", int'(full_digital), 0);
        check("R1 out_valid", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after release", int'(out_valid), 0);

        gain_cal = 16'd16384;
        gain_stn = 16'd16384;
        step_up  = 16'd16384;
        step_dn  = 16'd8192;

        // R7: weight 0 gives pure analog.
        send(1000, -1000, -2000, 2000, 1'b0, "R7 all-analog");
        // R2: rise 0 -> 16384 -> 32768 -> 49152 -> 65535 (saturated).
        for (int i = 0; i < 4; i++) send(1000, -1000, -2000, 2000, 1'b1, "R2 rise");
        send(1000, -1000, -2000, 2000, 1'b1, "R2 saturated");

        // R6: at full digital, probe the gain path.
        gain_cal = 16'd32768; gain_stn = 16'd24576;
        send(0, 0, 20000, -30000, 1'b1, "R6 saturate");
        gain_cal = 16'd24576; gain_stn = 16'd16384;
        send(0, 0, 3, -3, 1'b1, "R6 rounding");
        gain_cal = 16'd20000; gain_stn = 16'd18000;
        send(0, 0, 12345, -7777, 1'b1, "R6 odd gains");
        gain_cal = 16'd16384; gain_stn = 16'd16384;

        // R4: partial fall then reverse.
        send(5000, 5000, -5000, -5000, 1'b0, "R4 fall");
        send(5000, 5000, -5000, -5000, 1'b0, "R4 fall");
        send(5000, 5000, -5000, -5000, 1'b1, "R4 reverse");
        send(5000, 5000, -5000, -5000, 1'b1, "R4 back to digital");

        // R3: full fall to zero.
        for (int i = 0; i < 9; i++) send(-300, 700, 900, -1100, 1'b0, "R3 fall");

        // R5: zero step holds the weight.
        step_up = 16'd0;
        send(2000, 2000, -2000, -2000, 1'b1, "R5 zero step");
        step_up = 16'd1000;
        send(2000, 2000, -2000, -2000, 1'b1, "R5 small step");
        step_up = 16'd0;
        send(2000, 2000, -2000, -2000, 1'b1, "R5 hold");
        // Toggle the request without a strobe: weight must not move.
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            blend_req = ~blend_req;
        end
        send(2000, 2000, -2000, -2000, 1'b1, "R5 no strobe");

        // R7: mid weights with extreme values.
        step_up = 16'd12345;
        send(32767, -32768, -32768, 32767, 1'b1, "R7 extremes");
        send(-12345, 23456, 31000, -31000, 1'b1, "R7 mid");
        send(7, -7, 9, -9, 1'b1, "R7 small");

        // R2: one step spanning the rest of the range.
        step_up = 16'd65535;
        send(100, 200, 300, 400, 1'b1, "R2 big step");
        send(100, 200, 300, 400, 1'b1, "R2 full digital");

        repeat (6) @(negedge clk);
        check("R8 output count", n_seen, n_sent);
        check("R8 scoreboard empty", sb.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule